// File: doc/BRIEF.md
# Privileged Interrupt Stack Frame Sequencer

This block carries out the register and stack work of moving a processor from a virtualized real-mode context to the most privileged level when an interrupt is taken. A single start pulse captures the following values:

- the interrupted context: four data segment selectors, the stack selector and pointer, the flags, and the code selector and instruction pointer;
- the privileged stack selector and pointer from the task-state input;
- the target gate's code selector and entry offset;
- the gate size and whether the gate is an interrupt gate or a trap gate.

The block then writes a nine-entry frame onto the privileged stack through a valid/ready memory write port. It moves the stack pointer down before each write. When the last entry has been accepted, it presents the new register values and raises a done pulse.

The surrounding control logic fetches and checks the gate descriptor before it pulses start. It takes the new register values when done is high. The gate size sets the width of each stack entry and the address step between entries. It also sets how the new instruction pointer is masked.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, busy_o, done_o and wr_valid_o are 0 and every new_* output is 0.
- R2: When start_i is high while busy_o is 0, busy_o is 1 from the next cycle up to and including the done_o cycle, and then returns to 0. A start_i pulse while busy_o is 1 is ignored, and the frame in progress keeps the context captured by the first start.
- R3: Exactly nine writes are issued per frame, in this order: GS, FS, DS, ES, old SS, old ESP, saved flags, old CS, old EIP.
- R4: The step is 4 for a 32-bit gate (gate32_i=1) and 2 for a 16-bit gate. The first write address is tss_esp0_i minus the step, and each later write address is the previous one minus the step.
- R5: With a 32-bit gate, wr_size32_o is 1. Selector entries are zero-extended to 32 bits, and the other entries are written at full width. With a 16-bit gate, wr_size32_o is 0 and every entry carries its low 16 bits, with bits 31:16 zero.
- R6: The flags entry holds eflags_i exactly as captured at start, before any flag is cleared.
- R7: new_eflags_o equals the captured flags with bit 8 (trap) and bit 16 (resume) cleared. Bit 9 (interrupt enable) is also cleared when intgate_i=1 and is kept when intgate_i=0.
- R8: new_ss_o equals tss_ss0_i and new_esp_o equals tss_esp0_i minus nine steps, both modulo 2^32.
- R9: new_gs_o, new_fs_o, new_ds_o and new_es_o are 0 and new_cs_o equals gate_sel_i. new_eip_o equals gate_off_i for a 32-bit gate, or gate_off_i AND 0000FFFFh for a 16-bit gate.
- R10: While wr_valid_o is 1 and wr_ready_i is 0, wr_valid_o stays 1 and wr_addr_o and wr_data_o do not change. The frame advances only when an entry is accepted.
- R11: done_o is high for exactly one cycle, in the cycle after the ninth write is accepted. The new_* outputs keep their values after done_o until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when not busy |
| gate32_i | input | 1 | 1 = 32-bit gate, 0 = 16-bit gate |
| intgate_i | input | 1 | 1 = interrupt gate (clears IF), 0 = trap gate |
| gs_i | input | 16 | Current GS selector |
| fs_i | input | 16 | Current FS selector |
| ds_i | input | 16 | Current DS selector |
| es_i | input | 16 | Current ES selector |
| ss_i | input | 16 | Current stack selector |
| esp_i | input | 32 | Current stack pointer |
| eflags_i | input | 32 | Current flags |
| cs_i | input | 16 | Current code selector |
| eip_i | input | 32 | Return instruction pointer |
| tss_ss0_i | input | 16 | Privileged stack selector from the task state |
| tss_esp0_i | input | 32 | Privileged stack pointer from the task state |
| gate_sel_i | input | 16 | Gate code selector |
| gate_off_i | input | 32 | Gate entry offset |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 32 | Write address (offset in the new stack segment) |
| wr_data_o | output | 32 | Write data |
| wr_size32_o | output | 1 | 1 = 32-bit write, 0 = 16-bit write |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_gs_o | output | 16 | New GS |
| new_fs_o | output | 16 | New FS |
| new_ds_o | output | 16 | New DS |
| new_es_o | output | 16 | New ES |
| new_ss_o | output | 16 | New stack selector |
| new_esp_o | output | 32 | New stack pointer |
| new_eflags_o | output | 32 | New flags |
| new_cs_o | output | 16 | New code selector |
| new_eip_o | output | 32 | New instruction pointer |

## Verification
Assertions check, on every cycle:
- that address and data stay held while a write is stalled;
- that each accepted write is followed by an address exactly one step lower;
- that a start from idle raises busy and a write request;
- that done is a single-cycle pulse after which busy falls;
- that the trap and resume bits are clear whenever done is high.

Only the bench scenarios can show the rest. These are the slot order and the data formatting per gate size, that the pushed flags are the unmodified copy, and the gate-type dependence of the interrupt-enable bit. They also cover the final stack pointer and instruction pointer masking, and that a start during a frame is ignored. The bench compares each of these against values it computes itself, over random contexts and random ready stalls.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
    localparam int XLEN     = 32;
    localparam int SEL_W    = 16;
    localparam int N_SLOTS  = 9;
    localparam int SLOT_W   = $clog2(N_SLOTS);
    localparam int HALF_W   = XLEN / 2;
    localparam int TF_BIT   = 8;
    localparam int IF_BIT   = 9;
    localparam int RF_BIT   = 16;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // captured interrupted context
    typedef struct packed {
        sel_t  gs;
        sel_t  fs;
        sel_t  ds;
        sel_t  es;
        sel_t  ss;
        word_t esp;
        word_t flags;
        sel_t  cs;
        word_t eip;
    } saved_ctx_t;
endpackage

// File: rtl/irq_frame_flags.sv
module irq_frame_flags
    import irq_frame_pkg::*;
(
    input  word_t flags_i,
    input  logic  intgate_i,
    output word_t flags_o
);
    word_t clr_mask;

    always_comb begin
        clr_mask         = '0;
        clr_mask[TF_BIT] = 1'b1;
        clr_mask[RF_BIT] = 1'b1;
        clr_mask[IF_BIT] = intgate_i;
        flags_o          = flags_i & ~clr_mask;
    end
endmodule

// File: rtl/irq_frame_slot_sel.sv
module irq_frame_slot_sel
    import irq_frame_pkg::*;
(
    input  saved_ctx_t        ctx_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              gate32_i,
    output word_t             data_o
);
    word_t slot_val [N_SLOTS];
    logic  slot_is_sel [N_SLOTS];

    always_comb begin
        slot_val[0] = word_t'(ctx_i.gs);
        slot_val[1] = word_t'(ctx_i.fs);
        slot_val[2] = word_t'(ctx_i.ds);
        slot_val[3] = word_t'(ctx_i.es);
        slot_val[4] = word_t'(ctx_i.ss);
        slot_val[5] = ctx_i.esp;
        slot_val[6] = ctx_i.flags;
        slot_val[7] = word_t'(ctx_i.cs);
        slot_val[8] = ctx_i.eip;
    end

    // selector entries are padded to a full slot
    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_kind
            if (g == 5 || g == 6 || g == 8) begin : g_wide
                assign slot_is_sel[g] = 1'b0;
            end else begin : g_sel
                assign slot_is_sel[g] = 1'b1;
            end
        end
    endgenerate

    word_t raw;
    logic  raw_sel;

    always_comb begin
        raw     = '0;
        raw_sel = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (slot_i == SLOT_W'(i)) begin
                raw     = slot_val[i];
                raw_sel = slot_is_sel[i];
            end
        end
        if (gate32_i) begin
            data_o = raw_sel ? word_t'(raw[SEL_W-1:0]) : raw;
        end else begin
            data_o = word_t'(raw[HALF_W-1:0]);
        end
    end
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
    import irq_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        gate32_i,
    input  logic        intgate_i,
    input  logic [15:0] gs_i,
    input  logic [15:0] fs_i,
    input  logic [15:0] ds_i,
    input  logic [15:0] es_i,
    input  logic [15:0] ss_i,
    input  logic [31:0] esp_i,
    input  logic [31:0] eflags_i,
    input  logic [15:0] cs_i,
    input  logic [31:0] eip_i,
    input  logic [15:0] tss_ss0_i,
    input  logic [31:0] tss_esp0_i,
    input  logic [15:0] gate_sel_i,
    input  logic [31:0] gate_off_i,
    output logic        wr_valid_o,
    input  logic        wr_ready_i,
    output logic [31:0] wr_addr_o,
    output logic [31:0] wr_data_o,
    output logic        wr_size32_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] new_gs_o,
    output logic [15:0] new_fs_o,
    output logic [15:0] new_ds_o,
    output logic [15:0] new_es_o,
    output logic [15:0] new_ss_o,
    output logic [31:0] new_esp_o,
    output logic [31:0] new_eflags_o,
    output logic [15:0] new_cs_o,
    output logic [31:0] new_eip_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
    localparam word_t STEP_WIDE   = word_t'(XLEN / 8);
    localparam word_t STEP_NARROW = word_t'(XLEN / 16);
    localparam word_t LOW_MASK    = word_t'({HALF_W{1'b1}});

    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] slot;
        word_t             sp;
        saved_ctx_t        ctx;
        logic              gate32;
        word_t             flags_new;
        sel_t              ss0;
        sel_t              gsel;
        word_t             goff;
        sel_t              o_gs;
        sel_t              o_fs;
        sel_t              o_ds;
        sel_t              o_es;
        sel_t              o_ss;
        word_t             o_esp;
        word_t             o_flags;
        sel_t              o_cs;
        word_t             o_eip;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    word_t step;
    word_t push_addr;
    word_t push_data;
    word_t start_flags_new;
    logic  accept;

    irq_frame_flags u_flags (
        .flags_i   (eflags_i),
        .intgate_i (intgate_i),
        .flags_o   (start_flags_new)
    );

    irq_frame_slot_sel u_slot (
        .ctx_i    (r_q.ctx),
        .slot_i   (r_q.slot),
        .gate32_i (r_q.gate32),
        .data_o   (push_data)
    );

    always_comb begin
        step      = r_q.gate32 ? STEP_WIDE : STEP_NARROW;
        push_addr = r_q.sp - step;
        accept    = (r_q.state == ST_PUSH) && wr_ready_i;

        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state     = ST_PUSH;
                    r_d.slot      = '0;
                    r_d.sp        = tss_esp0_i;
                    r_d.gate32    = gate32_i;
                    r_d.flags_new = start_flags_new;
                    r_d.ss0       = tss_ss0_i;
                    r_d.gsel      = gate_sel_i;
                    r_d.goff      = gate_off_i;
                    r_d.ctx.gs    = gs_i;
                    r_d.ctx.fs    = fs_i;
                    r_d.ctx.ds    = ds_i;
                    r_d.ctx.es    = es_i;
                    r_d.ctx.ss    = ss_i;
                    r_d.ctx.esp   = esp_i;
                    r_d.ctx.flags = eflags_i;
                    r_d.ctx.cs    = cs_i;
                    r_d.ctx.eip   = eip_i;
                end
            end
            ST_PUSH: begin
                if (accept) begin
                    r_d.sp = push_addr;
                    if (r_q.slot == LAST_SLOT) begin
                        r_d.state   = ST_DONE;
                        r_d.o_gs    = '0;
                        r_d.o_fs    = '0;
                        r_d.o_ds    = '0;
                        r_d.o_es    = '0;
                        r_d.o_ss    = r_q.ss0;
                        r_d.o_esp   = push_addr;
                        r_d.o_flags = r_q.flags_new;
                        r_d.o_cs    = r_q.gsel;
                        r_d.o_eip   = r_q.gate32 ? r_q.goff : (r_q.goff & LOW_MASK);
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_valid_o   = (r_q.state == ST_PUSH);
    assign wr_addr_o    = push_addr;
    assign wr_data_o    = push_data;
    assign wr_size32_o  = r_q.gate32;
    assign busy_o       = (r_q.state != ST_IDLE);
    assign done_o       = (r_q.state == ST_DONE);
    assign new_gs_o     = r_q.o_gs;
    assign new_fs_o     = r_q.o_fs;
    assign new_ds_o     = r_q.o_ds;
    assign new_es_o     = r_q.o_es;
    assign new_ss_o     = r_q.o_ss;
    assign new_esp_o    = r_q.o_esp;
    assign new_eflags_o = r_q.o_flags;
    assign new_cs_o     = r_q.o_cs;
    assign new_eip_o    = r_q.o_eip;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_ready_i && !done_o && wr_valid_o && r_q.slot != LAST_SLOT)
        |=> (wr_addr_o == $past(wr_addr_o) - (wr_size32_o ? STEP_WIDE : STEP_NARROW)));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && wr_valid_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R7
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!new_eflags_o[TF_BIT] && !new_eflags_o[RF_BIT]));
endmodule

// File: tb/irq_frame_seq_tb.sv
module irq_frame_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        gate32_i = 1'b0;
    logic        intgate_i = 1'b0;
    logic [15:0] gs_i = '0, fs_i = '0, ds_i = '0, es_i = '0, ss_i = '0, cs_i = '0;
    logic [31:0] esp_i = '0, eflags_i = '0, eip_i = '0;
    logic [15:0] tss_ss0_i = '0, gate_sel_i = '0;
    logic [31:0] tss_esp0_i = '0, gate_off_i = '0;
    logic        wr_ready_i = 1'b0;
    logic        wr_valid_o, wr_size32_o, busy_o, done_o;
    logic [31:0] wr_addr_o, wr_data_o;
    logic [15:0] new_gs_o, new_fs_o, new_ds_o, new_es_o, new_ss_o, new_cs_o;
    logic [31:0] new_esp_o, new_eflags_o, new_eip_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    irq_frame_seq u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_flags(input logic [31:0] f, input bit ig);
        logic [31:0] r;
        r = f;
        r[8] = 1'b0;
        r[16] = 1'b0;
        if (ig) r[9] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] fmt(input logic [31:0] v, input bit is_sel, input bit g32);
        if (!g32) return {16'h0, v[15:0]};
        if (is_sel) return {16'h0, v[15:0]};
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_frame(input bit g32, input bit ig, input int stall_pct, input bit inject,
                             input logic [31:0] esp0, input logic [31:0] goff);
        logic [31:0] ed [9];
        logic [31:0] step, a, e_eflags, e_eip, e_esp;
        logic [15:0] e_ss0, e_gsel;
        int idx;
        bit prev_stall;
        logic [31:0] prev_a, prev_d;
        int guard;

        @(negedge clk);
        gate32_i   = g32;
        intgate_i  = ig;
        gs_i = 16'($urandom); fs_i = 16'($urandom); ds_i = 16'($urandom); es_i = 16'($urandom);
        ss_i = 16'($urandom); cs_i = 16'($urandom);
        esp_i = $urandom; eflags_i = $urandom | 32'h0001_0300; eip_i = $urandom;
        tss_ss0_i = 16'($urandom); tss_esp0_i = esp0;
        gate_sel_i = 16'($urandom); gate_off_i = goff;
        start_i = 1'b1;

        ed[0] = fmt({16'h0, gs_i}, 1, g32);
        ed[1] = fmt({16'h0, fs_i}, 1, g32);
        ed[2] = fmt({16'h0, ds_i}, 1, g32);
        ed[3] = fmt({16'h0, es_i}, 1, g32);
        ed[4] = fmt({16'h0, ss_i}, 1, g32);
        ed[5] = fmt(esp_i, 0, g32);
        ed[6] = fmt(eflags_i, 0, g32);
        ed[7] = fmt({16'h0, cs_i}, 1, g32);
        ed[8] = fmt(eip_i, 0, g32);
        step     = g32 ? 32'd4 : 32'd2;
        e_eflags = exp_flags(eflags_i, ig);
        e_eip    = g32 ? goff : {16'h0, goff[15:0]};
        e_esp    = esp0 - 9 * step;
        e_ss0    = tss_ss0_i;
        e_gsel   = gate_sel_i;
        a        = esp0;

        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", {31'h0, busy_o}, 32'h1);
        // scramble the inputs: the frame must use the captured copy
        gs_i = ~gs_i; eflags_i = ~eflags_i; tss_esp0_i = ~tss_esp0_i; gate32_i = ~g32;
        idx = 0;
        prev_stall = 1'b0;
        prev_a = '0;
        prev_d = '0;
        guard = 0;
        while (!done_o && guard < 2000) begin
            guard++;
            start_i = (inject && idx == 3);
            if (wr_valid_o) begin
                if (prev_stall)
                    chk(wr_addr_o == prev_a && wr_data_o == prev_d, "R10 hold while stalled", wr_addr_o, prev_a);
                if (($urandom % 100) >= stall_pct) begin
                    wr_ready_i = 1'b1;
                    if (idx < 9) begin
                        a = a - step;
                        chk(wr_addr_o == a, g32 ? "R4 address step 4" : "R4 address step 2", wr_addr_o, a);
                        chk(wr_data_o == ed[idx], idx == 6 ? "R6 saved flags entry" : "R3 entry order/value", wr_data_o, ed[idx]);
                        chk(wr_size32_o == g32, "R5 write size", {31'h0, wr_size32_o}, {31'h0, g32});
                    end
                    idx++;
                    prev_stall = 1'b0;
                end else begin
                    wr_ready_i = 1'b0;
                    prev_stall = 1'b1;
                    prev_a = wr_addr_o;
                    prev_d = wr_data_o;
                end
            end else begin
                wr_ready_i = $urandom % 2;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        wr_ready_i = 1'b0;
        chk(idx == 9, "R3 nine writes", idx, 9);
        chk(done_o && busy_o, "R11 done with busy", {30'h0, done_o, busy_o}, 32'h3);
        chk(new_eflags_o == e_eflags, ig ? "R7 flags interrupt gate" : "R7 flags trap gate", new_eflags_o, e_eflags);
        chk(new_ss_o == e_ss0, "R8 new ss", {16'h0, new_ss_o}, {16'h0, e_ss0});
        chk(new_esp_o == e_esp, "R8 new esp", new_esp_o, e_esp);
        chk({new_gs_o, new_fs_o, new_ds_o, new_es_o} == 64'h0, "R9 data segs zero", {new_gs_o, new_fs_o}, 32'h0);
        chk(new_cs_o == e_gsel, "R9 new cs", {16'h0, new_cs_o}, {16'h0, e_gsel});
        chk(new_eip_o == e_eip, "R9 new eip", new_eip_o, e_eip);
        @(negedge clk);
        chk(!done_o && !busy_o, "R11 single done pulse", {30'h0, done_o, busy_o}, 32'h0);
        chk(new_esp_o == e_esp && new_eip_o == e_eip, "R11 outputs held", new_esp_o, e_esp);
        chk(!wr_valid_o, "R2 idle no write", {31'h0, wr_valid_o}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !wr_valid_o, "R1 reset control", {29'h0, busy_o, done_o, wr_valid_o}, 32'h0);
        chk(new_esp_o == 0 && new_eflags_o == 0 && new_eip_o == 0 && new_cs_o == 0 && new_ss_o == 0,
            "R1 reset outputs", new_esp_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 idle after reset", {31'h0, busy_o}, 32'h0);

        // directed corners
        run_frame(1'b1, 1'b1, 0, 1'b0, 32'h0000_1000, 32'hDEAD_BEEF);
        run_frame(1'b0, 1'b0, 0, 1'b0, 32'h0000_0004, 32'h1234_5678);
        run_frame(1'b1, 1'b0, 60, 1'b1, 32'h0000_0008, 32'hFFFF_0001);
        run_frame(1'b0, 1'b1, 70, 1'b1, 32'hFFFF_FFFE, 32'hABCD_EF01);
        // random mix
        for (int n = 0; n < 40; n++) begin
            run_frame(1'($urandom), 1'($urandom), int'($urandom % 80), 1'($urandom),
                      $urandom, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule